// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a procedure return will resume fetching. The fetch or decode stage supplies class flags for each instruction it sees. A call is a branch-with-link in its immediate or exchange form. A link-register setup is a move or ALU operation that copies the program counter into the link register, which usually comes just before a branch that acts as a call. A return candidate is either a load into the PC from an address based on the stack pointer, or a move or ALU operation that writes the PC from the link register. With each push class, the stage also supplies the link value that the stack should save.

A push class writes the supplied address onto a small circular stack. A return class pops the top entry, and one cycle later the block raises a predicted next-fetch address together with a valid flag. Once the stack is full, a further push overwrites the oldest entry. A pop from an empty stack gives no prediction.

Two enables gate all activity: a global flow-prediction enable and an enable local to this stack. A flush input clears the stack in a single cycle. Address bit 0 travels unchanged through the stack, so the instruction-set state can be carried with the address. DEPTH must be a power of two.

Top module: `ras_predictor`

## Requirements
- R1: When `is_call_i` is 1 and the block is enabled, `push_addr_i` is pushed. While the stack is not full, the entry count grows by one.
- R2: When `is_lr_setup_i` is 1 and the block is enabled, `push_addr_i` is pushed exactly as a call would push it.
- R3: When `ret_sp_load_i` is 1, the stack is enabled and the stack is not empty, the top entry is popped. `pred_valid_o` is 1 in the next cycle only, with `pred_addr_o` equal to that entry. In any cycle that follows a cycle with no return flag, `pred_valid_o` is 0.
- R4: When `ret_lr_write_i` is 1, the block pops and predicts in the same way as for R3.
- R5: The block is enabled only when both `flow_en_i` and `ras_en_i` are 1. Otherwise, all class flags are ignored, the stack contents are kept, and `pred_valid_o` is 0 in the next cycle.
- R6: The stack holds DEPTH entries (8 by default). A push into a full stack overwrites the oldest entry. After DEPTH+1 pushes, DEPTH pops return the newest DEPTH addresses, newest first.
- R7: When `flush_i` is 1, the stack is empty in the next cycle and `pred_valid_o` is 0 in that cycle. A flush takes priority over any push or pop in the same cycle.
- R8: A return on an empty stack gives `pred_valid_o` = 0 in the next cycle.
- R9: When a push flag and a return flag are both 1 in one cycle on a non-empty stack, the prediction is the old top entry, the new address replaces that entry, and the depth is unchanged. On an empty stack, the same input pair gives no prediction and pushes the new address.
- R10: All ADDR_W bits, including bit 0, are returned exactly as they were pushed.
- R11: A synchronous active-high `rst` empties the stack and sets `pred_valid_o` and `pred_addr_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_en_i | input | 1 | Global flow-prediction enable |
| ras_en_i | input | 1 | Local enable for this stack |
| flush_i | input | 1 | Empty the stack |
| is_call_i | input | 1 | Branch-with-link seen (immediate or exchange form) |
| is_lr_setup_i | input | 1 | PC copied into the link register |
| ret_sp_load_i | input | 1 | PC loaded from a stack-pointer-based address |
| ret_lr_write_i | input | 1 | PC written from the link register |
| push_addr_i | input | ADDR_W | Return address to save |
| pred_valid_o | output | 1 | Prediction valid (one-cycle pulse) |
| pred_addr_o | output | ADDR_W | Predicted next-fetch address |

## Verification
Some properties are checked on every cycle: the entry count stays within its bounds, and it grows, shrinks or saturates as each push or pop requires. The valid flag is also checked every cycle: it stays low after a cycle that was disabled, flushed, empty or had no return. Other behaviour can only be shown by the bench's scenarios. These are the order of the returned addresses, the survival of bit 0, the replace-in-place result of a same-cycle push and pop, the loss of the oldest entry on overflow, and the fact that ignored flags leave the stored entries unchanged.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } ras_op_t;
endpackage

// File: rtl/ras_classify.sv
`timescale 1ns/1ps
module ras_classify
  import ras_pkg::*;
(
  input  logic    flow_en,
  input  logic    local_en,
  input  logic    flush,
  input  logic    is_call,
  input  logic    is_lr_setup,
  input  logic    ret_sp_load,
  input  logic    ret_lr_write,
  output ras_op_t op
);
  logic active;

  always_comb begin
    active  = flow_en && local_en && !flush;
    op.push = active && (is_call || is_lr_setup);
    op.pop  = active && (ret_sp_load || ret_lr_write);
  end
endmodule

// File: rtl/ras_ptr.sv
`timescale 1ns/1ps
module ras_ptr
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  ras_op_t                      op,
  output logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [$clog2(DEPTH)-1:0]     wr_idx,
  output logic                         wr_en,
  output logic                         rd_en,
  output logic                         empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0] top;
  logic [CNT_W-1:0] count;
  logic             replace;

  always_comb begin
    empty   = (count == '0);
    replace = op.push && op.pop && !empty;
    rd_idx  = top;
    rd_en   = op.pop && !empty;
    wr_en   = op.push;
    wr_idx  = replace ? top : top + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      top   <= '0;
      count <= '0;
    end else if (replace) begin
      top   <= top;
    end else if (op.push) begin
      top <= top + 1'b1;
      if (count != FULL) count <= count + 1'b1;
    end else if (op.pop && !empty) begin
      top   <= top - 1'b1;
      count <= count - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0)); // R7
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    (op.push && !op.pop && count != FULL && !flush) |=> (count == $past(count) + 1'b1)); // R1
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (op.pop && !op.push && !empty && !flush) |=> (count == $past(count) - 1'b1)); // R3
  AST_FULL_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (op.push && count == FULL && !flush) |=> (count == FULL)); // R6
endmodule

// File: rtl/ras_mem.sv
`timescale 1ns/1ps
module ras_mem #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [ADDR_W-1:0]        wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [ADDR_W-1:0]        rd_data
);
  logic [ADDR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/ras_predictor.sv
`timescale 1ns/1ps
module ras_predictor
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flow_en_i,
  input  logic              ras_en_i,
  input  logic              flush_i,
  input  logic              is_call_i,
  input  logic              is_lr_setup_i,
  input  logic              ret_sp_load_i,
  input  logic              ret_lr_write_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_addr_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  ras_op_t          op;
  logic [PTR_W-1:0] rd_idx;
  logic [PTR_W-1:0] wr_idx;
  logic             wr_en;
  logic             rd_en;
  logic             empty;

  ras_classify u_classify (
    .flow_en      (flow_en_i),
    .local_en     (ras_en_i),
    .flush        (flush_i),
    .is_call      (is_call_i),
    .is_lr_setup  (is_lr_setup_i),
    .ret_sp_load  (ret_sp_load_i),
    .ret_lr_write (ret_lr_write_i),
    .op           (op)
  );

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush_i),
    .op     (op),
    .rd_idx (rd_idx),
    .wr_idx (wr_idx),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .empty  (empty)
  );

  ras_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (push_addr_i),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_data (pred_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_valid_o <= 1'b0;
    else     pred_valid_o <= rd_en;
  end

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    !(flow_en_i && ras_en_i) |=> !pred_valid_o); // R5
  AST_UNDERFLOW_SILENT: assert property (@(posedge clk) disable iff (rst)
    empty |=> !pred_valid_o); // R8
  AST_NO_RET_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    !(ret_sp_load_i || ret_lr_write_i) |=> !pred_valid_o); // R3
  AST_FLUSH_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !pred_valid_o); // R7
endmodule

// File: tb/tb_ras_predictor.sv
`timescale 1ns/1ps
module tb_ras_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flow_en_i = 1'b0, ras_en_i = 1'b0, flush_i = 1'b0;
  logic        is_call_i = 1'b0, is_lr_setup_i = 1'b0;
  logic        ret_sp_load_i = 1'b0, ret_lr_write_i = 1'b0;
  logic [31:0] push_addr_i = '0;
  logic        pred_valid_o;
  logic [31:0] pred_addr_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ras_predictor dut (
    .clk(clk), .rst(rst), .flow_en_i(flow_en_i), .ras_en_i(ras_en_i),
    .flush_i(flush_i), .is_call_i(is_call_i), .is_lr_setup_i(is_lr_setup_i),
    .ret_sp_load_i(ret_sp_load_i), .ret_lr_write_i(ret_lr_write_i),
    .push_addr_i(push_addr_i), .pred_valid_o(pred_valid_o), .pred_addr_o(pred_addr_o)
  );

  typedef struct packed {
    logic        call;
    logic        lrset;
    logic        rsp;
    logic        rlr;
    logic        fl;
    logic        ge;
    logic        le;
    logic [31:0] addr;
    logic        ev;
    logic [31:0] ea;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h1000_0004,1'b0,32'h0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,32'h2000_0009,1'b0,32'h0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b1,32'h2000_0009},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'h0,1'b1,32'h1000_0004},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'h3000_0000,1'b0,32'h0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,32'h0,1'b0,32'h0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h4000_0010,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'h0,1'b1,32'h4000_0010},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h6000_0001,1'b0,32'h0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h7000_0002,1'b1,32'h6000_0001},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b1,32'h7000_0002},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h8000_0000,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'h9000_0000,1'b0,32'h0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'hA000_0003,1'b0,32'h0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'h0,1'b1,32'hA000_0003},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0}
  };
  localparam string TAGS [NV] = '{
    "R1", "R2", "R10", "R4", "R8", "R5", "R5", "R5", "R1", "R5", "R5",
    "R10", "R9", "R9", "R8", "R1", "R7", "R7", "R9", "R9", "R3"
  };

  task automatic check(input logic ev, input logic [31:0] ea, input string tag);
    n_checks++;
    if (pred_valid_o !== ev || (ev && pred_addr_o !== ea)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               tag, pred_valid_o, pred_addr_o, ev, ea);
    end
  endtask

  task automatic drive(input vec_t v);
    is_call_i      = v.call;
    is_lr_setup_i  = v.lrset;
    ret_sp_load_i  = v.rsp;
    ret_lr_write_i = v.rlr;
    flush_i        = v.fl;
    flow_en_i      = v.ge;
    ras_en_i       = v.le;
    push_addr_i    = v.addr;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: valid=%0b addr=%h expected valid=0 addr=0 (run hung)",
             pred_valid_o, pred_addr_o);
    finish_run();
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check(1'b0, 32'h0, "R11");
    n_checks++;
    if (pred_addr_o !== 32'h0) begin
      n_fail++;
      $display("FAIL R11: addr=%h expected %h", pred_addr_o, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check(TBL[i].ev, TBL[i].ea, TAGS[i]);
    end

    // R6: overflow drops the oldest entry
    for (int k = 1; k <= 9; k++) begin
      v = '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,
            32'hC000_0000 | (32'(k) << 4) | 32'(k & 1),1'b0,32'h0};
      drive(v);
    end
    for (int k = 9; k >= 1; k--) begin
      v = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0};
      drive(v);
      check(k >= 2, 32'hC000_0000 | (32'(k) << 4) | 32'(k & 1), "R6");
    end

    // R11: reset mid-run empties the stack
    v = '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h1234_5678,1'b0,32'h0};
    drive(v);
    v = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0};
    drive(v);
    check(1'b1, 32'h1234_5678, "R3");
    v = '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h5555_0000,1'b0,32'h0};
    drive(v);
    rst = 1'b1;
    v = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0};
    drive(v);
    rst = 1'b0;
    check(1'b0, 32'h0, "R11");
    n_checks++;
    if (pred_addr_o !== 32'h0) begin
      n_fail++;
      $display("FAIL R11: addr=%h expected %h", pred_addr_o, 32'h0);
    end
    v = '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,32'h0,1'b0,32'h0};
    drive(v);
    check(1'b0, 32'h0, "R11");

    finish_run();
  end
endmodule